// File: doc/BRIEF.md
# Indexed configuration register port

This block is a byte-wide register file that a host reaches through a pair of neighbouring I/O addresses. A write to the lower address (the select port) stores an 8-bit register number. A read or write at the upper address (the value port) then reaches the register that number names. The host thus reaches 256 one-byte registers through only two I/O locations.

Not every register can be changed. A fixed map, spread irregularly across the 256 numbers, makes most of them read-only. A handful of registers come out of reset with fixed non-zero values, among them the base-address bytes for two serial ports. A single enable input switches decoding of both ports on or off. That input is driven from one bit of a bridge configuration register kept elsewhere. While the enable is low the ports ignore the host and keep their contents.

Numbers below the first writable register can never change. They always read zero, so only the upper slice of the number space has storage.

Top module: `cfg_index_port`

## Requirements
- R1: A write to the select port (io_addr == BASE_ADDR, default 0x3F0) while decode_en is high loads io_wdata into the select register. The select register resets to 0x00.
- R2: A read of the select port while decode_en is high returns the current select value on io_rdata.
- R3: A read of the value port (io_addr == BASE_ADDR+1, default 0x3F1) while decode_en is high returns the register the select value names. io_rdata takes the new value at the clock edge that samples io_rd and is valid from the following cycle on.
- R4: After reset, register 0xE0 reads 0x3C, 0xE2 reads 0x03, 0xE3 reads 0xFC, 0xE6 reads 0xDE, 0xE7 (serial port 1 base) reads 0xFE and 0xE8 (serial port 2 base) reads 0xBE. Every other register reads 0x00.
- R5: A value-port write has no effect when the select value is 0xFD–0xFF, 0xF9–0xFB, 0xF7, 0xF5, 0xF3, 0xE9–0xED, 0xE4, 0xE5 or any number up to 0xDF.
- R6: A value-port write to any other select value (0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8, 0xFC) stores io_wdata. The next value-port read returns it.
- R7: While decode_en is low, every read returns 0xFF. Writes to either port change neither the select register nor any data register.
- R8: Reads of any address other than the two ports return 0xFF. Writes there change nothing.
- R9: io_rdata changes only in a cycle that carries io_rd. Otherwise it holds its value. It resets to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| decode_en | input | 1 | Port decode enable from the bridge configuration bit |
| io_addr | input | ADDR_W (16) | I/O address of the access |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |

## Verification
A full sweep reads all 256 registers after reset to separate the six reset defaults from the zero background. A second sweep writes a marker byte to every register number and reads each one back. This tells the writable numbers from the read-only ones, and the irregular gaps in the protect map are where faults would hide. The same write and read pattern is repeated with decode disabled, and again at a foreign address, to show that neither changes any state. A seeded random mix of select, value and foreign accesses with a toggling enable then checks the sequence of select and data accesses against a reference model in the bench.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int          REG_W       = 8;
    localparam int          NUM_REGS    = 256;
    localparam logic [7:0]  FIRST_STORED = 8'hE0;

    // Writable register numbers; every other number is read-only.
    function automatic logic is_writable(input logic [7:0] num);
        return !(num inside {[8'h00:8'hDF], 8'hE4, 8'hE5, [8'hE9:8'hED],
                             8'hF3, 8'hF5, 8'hF7, [8'hF9:8'hFB],
                             [8'hFD:8'hFF]});
    endfunction

    // Value each register takes on reset.
    function automatic logic [7:0] reset_value(input logic [7:0] num);
        case (num)
            8'hE8:   return 8'hBE;
            8'hE7:   return 8'hFE;
            8'hE6:   return 8'hDE;
            8'hE3:   return 8'hFC;
            8'hE2:   return 8'h03;
            8'hE0:   return 8'h3C;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgp_wp_decode.sv
module cfgp_wp_decode (
    input  logic [7:0] num,
    output logic       writable
);
    always_comb begin
        writable = cfgp_pkg::is_writable(num);
    end
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank #(
    parameter logic [7:0] LO_IDX = cfgp_pkg::FIRST_STORED
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_data
);
    localparam int NSLOT  = cfgp_pkg::NUM_REGS - int'(LO_IDX);
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    typedef struct packed {
        logic [NSLOT-1:0][7:0] mem;
    } bank_t;

    bank_t bank_d, bank_q, bank_rst;
    logic  wr_ok;
    logic [7:0] wslot, rslot;

    cfgp_wp_decode i_wp (
        .num      (wr_idx),
        .writable (wr_ok)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_rst
        assign bank_rst.mem[g] = cfgp_pkg::reset_value(8'(int'(LO_IDX) + g));
    end

    assign wslot = wr_idx - LO_IDX;
    assign rslot = rd_idx - LO_IDX;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && wr_ok && (wr_idx >= LO_IDX)) begin
            bank_d.mem[wslot[SLOT_W-1:0]] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= bank_rst;
        else        bank_q <= bank_d;
    end

    always_comb begin
        if (rd_idx < LO_IDX) rd_data = 8'h00;
        else                 rd_data = bank_q.mem[rslot[SLOT_W-1:0]];
    end

    // R5
    wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfgp_pkg::is_writable(wr_idx)) |=> $stable(bank_q.mem));

    // R6
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfgp_pkg::is_writable(wr_idx) && (wr_idx >= LO_IDX))
        |=> (bank_q.mem[$past(wslot[SLOT_W-1:0])] == $past(wr_data)));

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              decode_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = BASE_ADDR;
    localparam logic [ADDR_W-1:0] VAL_ADDR = BASE_ADDR + 1'b1;

    typedef struct packed {
        logic [7:0] sel;
        logic [7:0] rdata;
    } port_t;

    port_t      st_d, st_q;
    logic       hit_sel, hit_val;
    logic [7:0] bank_rd;

    assign hit_sel = decode_en && (io_addr == SEL_ADDR);
    assign hit_val = decode_en && (io_addr == VAL_ADDR);

    cfgp_regbank #(.LO_IDX(cfgp_pkg::FIRST_STORED)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (io_wr && hit_val),
        .wr_idx  (st_q.sel),
        .wr_data (io_wdata),
        .rd_idx  (st_q.sel),
        .rd_data (bank_rd)
    );

    always_comb begin
        st_d = st_q;
        if (io_wr && hit_sel) st_d.sel = io_wdata;
        if (io_rd) begin
            if (hit_val)      st_d.rdata = bank_rd;
            else if (hit_sel) st_d.rdata = st_q.sel;
            else              st_d.rdata = 8'hFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sel: 8'h00, rdata: 8'hFF};
        else        st_q <= st_d;
    end

    assign io_rdata = st_q.rdata;

    // R1
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_en && io_wr && io_addr == SEL_ADDR) |=> (st_q.sel == $past(io_wdata)));

    // R2
    sel_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_en && io_rd && io_addr == SEL_ADDR) |=> (io_rdata == $past(st_q.sel)));

    // R7
    off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!decode_en && io_rd) |=> (io_rdata == 8'hFF));

    // R7
    off_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!decode_en) |=> $stable(st_q.sel));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd) |=> $stable(io_rdata));

endmodule

// File: tb/test_cfg_index_port.sv
`timescale 1ns/1ps
module test_cfg_index_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        decode_en = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [7:0] m_mem [256];
    logic [7:0] m_sel;

    always #4 clk = ~clk;

    cfg_index_port i_cfg_index_port (
        .clk(clk), .rst_n(rst_n), .decode_en(decode_en), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    function automatic logic tb_writable(input logic [7:0] n);
        case (n)
            8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6, 8'hE7, 8'hE8, 8'hEE, 8'hEF,
            8'hF0, 8'hF1, 8'hF2, 8'hF4, 8'hF6, 8'hF8, 8'hFC: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] tb_default(input logic [7:0] n);
        if (n == 8'hE0) return 8'h3C;
        if (n == 8'hE2) return 8'h03;
        if (n == 8'hE3) return 8'hFC;
        if (n == 8'hE6) return 8'hDE;
        if (n == 8'hE7) return 8'hFE;
        if (n == 8'hE8) return 8'hBE;
        return 8'h00;
    endfunction

    function automatic logic [7:0] tb_expect_rd(input logic en, input logic [15:0] a);
        if (!en) return 8'hFF;
        if (a == 16'h03F0) return m_sel;
        if (a == 16'h03F1) return m_mem[m_sel];
        return 8'hFF;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) m_mem[i] = tb_default(8'(i));
        m_sel = 8'h00;
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (decode_en && a == 16'h03F0) m_sel = d;
        else if (decode_en && a == 16'h03F1 && tb_writable(m_sel)) m_mem[m_sel] = d;
    endtask

    task automatic do_rd(input logic [15:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        e = tb_expect_rd(decode_en, a);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        check(tag, io_rdata, e);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] held;
        int unsigned seed_sink;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset rdata", io_rdata, 8'hFF);
        decode_en = 1'b1;
        do_rd(16'h03F0, "R1 reset select");

        // R4: sweep all register numbers after reset
        for (int i = 0; i < 256; i++) begin
            do_wr(16'h03F0, 8'(i));
            do_rd(16'h03F1, "R4 reset value");
        end

        // R5/R6: write a marker everywhere, read back
        for (int i = 0; i < 256; i++) begin
            do_wr(16'h03F0, 8'(i));
            do_wr(16'h03F1, 8'hA5 ^ 8'(i));
        end
        for (int i = 0; i < 256; i++) begin
            do_wr(16'h03F0, 8'(i));
            do_rd(16'h03F0, "R2 select readback");
            do_rd(16'h03F1, tb_writable(8'(i)) ? "R6 stored" : "R5 protected");
        end

        // R7: decode disabled
        do_wr(16'h03F0, 8'hE7);
        decode_en = 1'b0;
        do_wr(16'h03F0, 8'hF0);
        do_wr(16'h03F1, 8'h11);
        do_rd(16'h03F1, "R7 disabled read");
        do_rd(16'h03F0, "R7 disabled read");
        decode_en = 1'b1;
        do_rd(16'h03F0, "R7 select kept");
        do_rd(16'h03F1, "R7 contents kept");

        // R8: foreign address
        do_wr(16'h02F8, 8'h77);
        do_wr(16'h03F2, 8'h77);
        do_rd(16'h03F2, "R8 foreign read");
        do_rd(16'h03F0, "R8 select unchanged");
        do_rd(16'h03F1, "R8 data unchanged");

        // R9: rdata holds across non-read cycles
        do_rd(16'h03F1, "R3 data read");
        held = io_rdata;
        do_wr(16'h03F1, 8'h5A);
        repeat (3) @(negedge clk);
        check("R9 rdata hold", io_rdata, held);
        do_rd(16'h03F1, "R6 next read");

        // Random mix
        seed_sink = $urandom(32'd20240611);
        for (int k = 0; k < 3000; k++) begin
            int unsigned r;
            logic [15:0] a;
            r = $urandom;
            case (r % 5)
                0, 1: a = 16'h03F1;
                2, 3: a = 16'h03F0;
                default: a = 16'h03E0 + 16'(r[12:8]);
            endcase
            decode_en = (r[20:18] != 3'd0);
            if (a == 16'h03F0 && r[16]) begin
                // bias selects into the stored slice
                do_wr(a, 8'hE0 | 8'(r[27:23]));
            end else if (r[17]) begin
                do_wr(a, 8'(r[31:24]));
            end else begin
                do_rd(a, "R3 random read");
            end
        end
        decode_en = 1'b1;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule